// File: doc/BRIEF.md
# Daisy-Chained Readout Token Sequencer

This block sequences the readout of one link made of a parameterised number of chained readout chips (six by default). When a trigger arrives, each working chip captures its hit count for the event. One chip acts as the master and starts sending at once. After its own words it passes a token down the chain. Each later chip sends its own words when the token reaches it, then passes the token on. Every chip between the master and the far end relays everything that comes up from below it. The chip at the far end adds a closing trailer. Only the master drives the link output.

Each chip has a primary connection to its direct neighbours and an alternate connection that skips exactly one neighbour. A failure mask picks the routing. A failed chip is left out of the event, and its neighbours talk over the alternate path. The master role goes to the lowest working position and the end role goes to the highest. Two adjacent failed chips cannot be bridged, so that mask is flagged and triggers are refused. The master also runs a watchdog that closes the event with an error trailer if the chain does not return the data in time.

Top module: `rdo_chain`

## Requirements
- R1: After reset, `link_valid`, `evt_done` and `evt_err` are 0, and with an all-zero failure mask `cfg_err` is 0.
- R2: A link word is {kind[1:0], addr[4:0], data[DATA_W-1:0]} with kind in the top bits. Kind 2'b01 is a header whose data is the chip's hit count. Kind 2'b10 is a hit word whose data is the hit index, counting from 0. Kind 2'b11 is a trailer whose data is 0 normally and 1 after a timeout. The chip at position i uses address ADDR_BASE+i (8+i by default).
- R3: The words of an event appear on the link in this order: each working chip in increasing position, each chip giving its header followed by its hit words, then one trailer.
- R4: The master role goes to the lowest working position, and the first word of every event comes from that chip.
- R5: The end role goes to the highest working position, and the closing trailer carries that chip's address.
- R6: A failed chip sends no words. The chips on either side of a single failed chip exchange the token and the data over the alternate path.
- R7: If any two adjacent chips are marked failed, `cfg_err` is 1, triggers are ignored and no words appear on the link.
- R8: `evt_done` is high for exactly one cycle per event, in the same cycle as the trailer on the link. `evt_err` is high only together with `evt_done`, and only for a timeout trailer.
- R9: If `wd_limit` is nonzero and no trailer has reached the master within `wd_limit` cycles after it passes the token, the master sends a trailer with its own address and data 1, and raises `evt_done` and `evt_err`. A `wd_limit` of 0 disables the watchdog.
- R10: A trigger is ignored while any chip is still busy with an earlier event.
- R11: A chip with a hit count of zero still sends its header and sends no hit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Start-of-event pulse |
| hits | input | N_CHIPS*HIT_W | Hit count per chip; chip i uses bits [i*HIT_W +: HIT_W] |
| fail_mask | input | N_CHIPS | Bit i set marks chip i as failed |
| wd_limit | input | WD_W | Watchdog limit in cycles, 0 disables it |
| link_valid | output | 1 | Link word valid |
| link_word | output | 2+5+DATA_W | Link word (kind, address, data) |
| evt_done | output | 1 | Event closed (pulse) |
| evt_err | output | 1 | Event closed by the watchdog (pulse) |
| cfg_err | output | 1 | Unsupported failure mask (adjacent failures) |

## Verification
The assertions check on every cycle that:
- the link opens each event with a header;
- every word comes from a chip that is not masked as failed;
- a trailer and `evt_done` always appear together, and the trailer's data bit agrees with `evt_err`;
- an unsupported mask held steady keeps the link silent.

The exact word order across the chain, the bypass routing under different masks, the choice of master and end chip, the timeout cut-off and the refusal of a trigger during a busy event only show up in the bench's directed scenarios. Each of those scenarios compares the captured link stream with one computed from the hit counts and the mask.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
   localparam int ADDR_W = 5;

   typedef enum logic [1:0] {
      K_NONE = 2'b00,
      K_HDR  = 2'b01,
      K_DAT  = 2'b10,
      K_TRL  = 2'b11
   } kind_t;

   typedef enum logic [1:0] {
      ROLE_SLAVE  = 2'd0,
      ROLE_MASTER = 2'd1,
      ROLE_END    = 2'd2
   } role_t;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_WAIT = 3'd1,
      S_SEND = 3'd2,
      S_TAIL = 3'd3,
      S_FWD  = 3'd4
   } chip_st_t;
endpackage

// File: rtl/rdo_roles.sv
module rdo_roles #(
   parameter int N_CHIPS = 6,
   localparam int IW = $clog2(N_CHIPS)
) (
   input  logic [N_CHIPS-1:0] fail_mask,
   output logic [N_CHIPS-1:0] is_master,
   output logic [N_CHIPS-1:0] is_end,
   output logic [IW-1:0]      master_idx,
   output logic               cfg_err
);
   logic got_m;
   logic got_e;

   // lowest working position takes the master role
   always_comb begin
      is_master  = '0;
      master_idx = '0;
      got_m      = 1'b0;
      for (int i = 0; i < N_CHIPS; i++) begin
         if (!fail_mask[i] && !got_m) begin
            is_master[i] = 1'b1;
            master_idx   = IW'(i);
            got_m        = 1'b1;
         end
      end
   end

   // highest working position takes the end role
   always_comb begin
      is_end = '0;
      got_e  = 1'b0;
      for (int i = N_CHIPS - 1; i >= 0; i--) begin
         if (!fail_mask[i] && !got_e) begin
            is_end[i] = 1'b1;
            got_e     = 1'b1;
         end
      end
   end

   // the alternate path skips one chip only
   assign cfg_err = |(fail_mask[N_CHIPS-1:1] & fail_mask[N_CHIPS-2:0]);
endmodule

// File: rtl/rdo_chip.sv
module rdo_chip
   import rdo_pkg::*;
#(
   parameter int HIT_W  = 4,
   parameter int DATA_W = 8,
   parameter int WD_W   = 8,
   localparam int WW    = 2 + ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  role_t             role,
   input  logic [ADDR_W-1:0] addr,
   input  logic              trig,
   input  logic [HIT_W-1:0]  hits,
   input  logic [WD_W-1:0]   wd_limit,
   input  logic              tok_in,
   input  logic              din_v,
   input  logic [WW-1:0]     din_w,
   output logic              tok_out,
   output logic              dout_v,
   output logic [WW-1:0]     dout_w,
   output logic              done_o,
   output logic              err_o,
   output logic              idle_o
);
   localparam logic [HIT_W:0]  IDX_ONE = (HIT_W+1)'(1);
   localparam logic [WD_W-1:0] WD_ONE  = WD_W'(1);

   chip_st_t         st;
   logic [HIT_W-1:0] nh;
   logic [HIT_W:0]   idx;
   logic [WD_W-1:0]  wd;
   logic             is_m;
   logic             din_trl;
   logic             wd_hit;

   assign is_m    = (role == ROLE_MASTER);
   assign din_trl = din_v && (din_w[WW-1 -: 2] == K_TRL);
   assign wd_hit  = is_m && (wd_limit != '0) && (wd == wd_limit - WD_ONE);
   assign idle_o  = (st == S_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         nh      <= '0;
         idx     <= '0;
         wd      <= '0;
         tok_out <= 1'b0;
         dout_v  <= 1'b0;
         dout_w  <= '0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         tok_out <= 1'b0;
         dout_v  <= 1'b0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
         case (st)
            S_IDLE: begin
               if (trig) begin
                  nh  <= hits;
                  idx <= '0;
                  st  <= is_m ? S_SEND : S_WAIT;
               end
            end
            S_WAIT: begin
               if (tok_in) st <= S_SEND;
            end
            S_SEND: begin
               dout_v <= 1'b1;
               if (idx == '0) dout_w <= {K_HDR, addr, DATA_W'(nh)};
               else           dout_w <= {K_DAT, addr, DATA_W'(idx - IDX_ONE)};
               idx <= idx + IDX_ONE;
               if (idx == {1'b0, nh}) begin
                  if (role == ROLE_END) begin
                     st <= S_TAIL;
                  end else begin
                     tok_out <= 1'b1;
                     wd      <= '0;
                     st      <= S_FWD;
                  end
               end
            end
            S_TAIL: begin
               dout_v <= 1'b1;
               dout_w <= {K_TRL, addr, DATA_W'(0)};
               st     <= S_IDLE;
            end
            S_FWD: begin
               if (din_v) begin
                  dout_v <= 1'b1;
                  dout_w <= din_w;
               end
               if (din_trl) begin
                  done_o <= is_m;
                  st     <= S_IDLE;
               end else if (wd_hit) begin
                  dout_v <= 1'b1;
                  dout_w <= {K_TRL, addr, DATA_W'(1)};
                  done_o <= 1'b1;
                  err_o  <= 1'b1;
                  st     <= S_IDLE;
               end else begin
                  wd <= wd + WD_ONE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rdo_chain.sv
module rdo_chain
   import rdo_pkg::*;
#(
   parameter int N_CHIPS   = 6,
   parameter int HIT_W     = 4,
   parameter int DATA_W    = 8,
   parameter int WD_W      = 8,
   parameter int ADDR_BASE = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        trig,
   input  logic [N_CHIPS*HIT_W-1:0]    hits,
   input  logic [N_CHIPS-1:0]          fail_mask,
   input  logic [WD_W-1:0]             wd_limit,
   output logic                        link_valid,
   output logic [2+ADDR_W+DATA_W-1:0]  link_word,
   output logic                        evt_done,
   output logic                        evt_err,
   output logic                        cfg_err
);
   localparam int WW = 2 + ADDR_W + DATA_W;
   localparam int IW = $clog2(N_CHIPS);

   if (N_CHIPS < 3) begin : g_bad_n
      $error("rdo_chain: N_CHIPS must be at least 3");
   end
   if (DATA_W < HIT_W) begin : g_bad_dw
      $error("rdo_chain: DATA_W must hold a hit count");
   end
   if (ADDR_BASE + N_CHIPS > (1 << ADDR_W)) begin : g_bad_addr
      $error("rdo_chain: addresses exceed the address field");
   end

   logic [N_CHIPS-1:0] is_master, is_end;
   logic [IW-1:0]      master_idx;
   logic [N_CHIPS-1:0] tok_out_w, tok_in_w, dv_w, div_w, done_w, err_w, idle_w, ctrig;
   logic [WW-1:0]      dw_w  [N_CHIPS];
   logic [WW-1:0]      diw_w [N_CHIPS];
   role_t              role_w [N_CHIPS];
   logic               accept;

   rdo_roles #(.N_CHIPS(N_CHIPS)) u_roles (
      .fail_mask  (fail_mask),
      .is_master  (is_master),
      .is_end     (is_end),
      .master_idx (master_idx),
      .cfg_err    (cfg_err)
   );

   assign accept = trig && !cfg_err && (&idle_w);

   for (genvar g = 0; g < N_CHIPS; g++) begin : g_chip
      localparam logic [ADDR_W-1:0] CHIP_ADDR = ADDR_W'(ADDR_BASE + g);

      assign ctrig[g]  = accept && !fail_mask[g];
      assign role_w[g] = is_master[g] ? ROLE_MASTER :
                         (is_end[g] ? ROLE_END : ROLE_SLAVE);

      // token arrives from above: direct neighbour or, around a failed one, the next-but-one
      if (g == 0) begin : g_tok_top
         assign tok_in_w[g] = 1'b0;
      end else if (g == 1) begin : g_tok_one
         assign tok_in_w[g] = tok_out_w[0];
      end else begin : g_tok_alt
         assign tok_in_w[g] = fail_mask[g-1] ? tok_out_w[g-2] : tok_out_w[g-1];
      end

      // data arrives from below by the same rule
      if (g == N_CHIPS - 1) begin : g_dat_bot
         assign div_w[g] = 1'b0;
         assign diw_w[g] = '0;
      end else if (g == N_CHIPS - 2) begin : g_dat_one
         assign div_w[g] = dv_w[g+1];
         assign diw_w[g] = dw_w[g+1];
      end else begin : g_dat_alt
         assign div_w[g] = fail_mask[g+1] ? dv_w[g+2] : dv_w[g+1];
         assign diw_w[g] = fail_mask[g+1] ? dw_w[g+2] : dw_w[g+1];
      end

      rdo_chip #(
         .HIT_W  (HIT_W),
         .DATA_W (DATA_W),
         .WD_W   (WD_W)
      ) u_chip (
         .clk      (clk),
         .rst_n    (rst_n),
         .role     (role_w[g]),
         .addr     (CHIP_ADDR),
         .trig     (ctrig[g]),
         .hits     (hits[g*HIT_W +: HIT_W]),
         .wd_limit (wd_limit),
         .tok_in   (tok_in_w[g]),
         .din_v    (div_w[g]),
         .din_w    (diw_w[g]),
         .tok_out  (tok_out_w[g]),
         .dout_v   (dv_w[g]),
         .dout_w   (dw_w[g]),
         .done_o   (done_w[g]),
         .err_o    (err_w[g]),
         .idle_o   (idle_w[g])
      );
   end

   assign link_valid = dv_w[master_idx];
   assign link_word  = dw_w[master_idx];
   assign evt_done   = done_w[master_idx];
   assign evt_err    = err_w[master_idx];
endmodule

// File: rtl/rdo_chain_chk.sv
module rdo_chain_chk
   import rdo_pkg::*;
#(
   parameter int N_CHIPS   = 6,
   parameter int DATA_W    = 8,
   parameter int ADDR_BASE = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [N_CHIPS-1:0]         fail_mask,
   input logic                       link_valid,
   input logic [2+ADDR_W+DATA_W-1:0] link_word,
   input logic                       evt_done,
   input logic                       evt_err,
   input logic                       cfg_err
);
   localparam int WW = 2 + ADDR_W + DATA_W;

   logic              in_evt;
   logic [1:0]        kind;
   logic [ADDR_W-1:0] src;
   logic              src_ok;

   assign kind = link_word[WW-1 -: 2];
   assign src  = link_word[DATA_W +: ADDR_W] - ADDR_W'(ADDR_BASE);

   always_comb begin
      src_ok = 1'b0;
      for (int i = 0; i < N_CHIPS; i++)
         if (src == ADDR_W'(i)) src_ok = !fail_mask[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          in_evt <= 1'b0;
      else if (evt_done)   in_evt <= 1'b0;
      else if (link_valid) in_evt <= 1'b1;
   end

   // R3
   hdr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_valid && !in_evt) |-> (kind == K_HDR));

   // R6
   healthy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_valid |-> src_ok);

   // R8
   done_on_trailer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |-> (link_valid && kind == K_TRL));

   // R8
   trailer_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_valid && kind == K_TRL) |-> evt_done);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |=> !evt_done);

   // R9
   err_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_valid && kind == K_TRL) |-> (link_word[DATA_W-1:0] == DATA_W'(evt_err)));

   // R7
   cfg_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && $past(cfg_err) && $past(cfg_err, 2) && !in_evt) |-> !link_valid);
endmodule

bind rdo_chain rdo_chain_chk #(
   .N_CHIPS   (N_CHIPS),
   .DATA_W    (DATA_W),
   .ADDR_BASE (ADDR_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fail_mask  (fail_mask),
   .link_valid (link_valid),
   .link_word  (link_word),
   .evt_done   (evt_done),
   .evt_err    (evt_err),
   .cfg_err    (cfg_err)
);

// File: tb/sim_rdo_chain.sv
module sim_rdo_chain;
   localparam int N  = 6;
   localparam int HW = 4;
   localparam int DW = 8;
   localparam int AB = 8;
   localparam int WW = 2 + 5 + DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0;
   logic [N*HW-1:0] hits = '0;
   logic [N-1:0]  fail_mask = '0;
   logic [7:0]    wd_limit = '0;
   logic          link_valid, evt_done, evt_err, cfg_err;
   logic [WW-1:0] link_word;

   int n_chk = 0;
   int n_fail = 0;

   logic [WW-1:0] cap [0:2047];
   int ncap = 0;
   int ndone = 0;
   int nerrev = 0;

   logic [WW-1:0] exp_w [0:127];
   int nexp = 0;

   always #5 clk = ~clk;

   rdo_chain #(.N_CHIPS(N), .HIT_W(HW), .DATA_W(DW), .WD_W(8), .ADDR_BASE(AB)) u0 (
      .clk(clk), .rst_n(rst_n), .trig(trig), .hits(hits), .fail_mask(fail_mask),
      .wd_limit(wd_limit), .link_valid(link_valid), .link_word(link_word),
      .evt_done(evt_done), .evt_err(evt_err), .cfg_err(cfg_err)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (link_valid) begin
            if (ncap < 2048) cap[ncap] = link_word;
            ncap++;
         end
         if (evt_done) begin
            ndone++;
            if (evt_err) nerrev++;
         end
      end
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung act=%0d exp=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_fail);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, expv);
      end
   endtask

   function automatic logic [WW-1:0] mk(input logic [1:0] k, input int pos, input int d);
      return {k, 5'(AB + pos), DW'(d)};
   endfunction

   task automatic build_exp(input logic [N*HW-1:0] h, input logic [N-1:0] m);
      int last = 0;
      nexp = 0;
      for (int i = 0; i < N; i++) begin
         if (!m[i]) begin
            int hv = int'(h[i*HW +: HW]);
            exp_w[nexp] = mk(2'b01, i, hv); nexp++;
            for (int k = 0; k < hv; k++) begin
               exp_w[nexp] = mk(2'b10, i, k); nexp++;
            end
            last = i;
         end
      end
      exp_w[nexp] = mk(2'b11, last, 0); nexp++;
   endtask

   task automatic run_event(input logic [N*HW-1:0] h, input logic [N-1:0] m,
                            input logic [7:0] wd, input bit dbl,
                            output int base, output int dbase, output int ebase);
      @(negedge clk);
      hits = h; fail_mask = m; wd_limit = wd;
      @(negedge clk);
      base = ncap; dbase = ndone; ebase = nerrev;
      trig = 1'b1;
      for (int c = 0; c < 400 && ndone == dbase; c++) begin
         @(negedge clk);
         trig = (dbl && c == 5);
      end
      trig = 1'b0;
      for (int c = 0; c < 80; c++) @(negedge clk);
   endtask

   task automatic cmp_stream(input int base, input string req);
      int n = ncap - base;
      int at = -1;
      chk(n == nexp, {req, " word count"}, n, nexp);
      for (int k = 0; k < n && k < nexp; k++)
         if (at < 0 && cap[base+k] !== exp_w[k]) at = k;
      if (at < 0) chk(1'b1, req, 0, 0);
      else        chk(1'b0, {req, " word order"}, cap[base+at], exp_w[at]);
   endtask

   task automatic t_reset();
      chk(link_valid == 1'b0, "R1 link_valid", link_valid, 0);
      chk(evt_done == 1'b0 && evt_err == 1'b0, "R1 done/err", {evt_done, evt_err}, 0);
      chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);
   endtask

   task automatic t_basic();
      int b, d, e;
      build_exp(24'h251413, 6'b000000);
      run_event(24'h251413, 6'b000000, 8'd0, 1'b0, b, d, e);
      chk(cap[b] == mk(2'b01, 0, 3), "R2 header word layout", cap[b], mk(2'b01, 0, 3));
      chk(cap[b+1] == mk(2'b10, 0, 0), "R2 hit word layout", cap[b+1], mk(2'b10, 0, 0));
      cmp_stream(b, "R3 full chain order");
      chk(ndone - d == 1, "R8 one done pulse", ndone - d, 1);
      chk(nerrev - e == 0, "R8 no error", nerrev - e, 0);
      build_exp(24'h0f0203, 6'b000000);
      run_event(24'h0f0203, 6'b000000, 8'd0, 1'b0, b, d, e);
      cmp_stream(b, "R3 second pattern");
   endtask

   task automatic t_zero();
      int b, d, e;
      build_exp(24'h000000, 6'b000000);
      run_event(24'h000000, 6'b000000, 8'd0, 1'b0, b, d, e);
      cmp_stream(b, "R11 headers only");
      chk(ncap - b == N + 1, "R11 word total", ncap - b, N + 1);
   endtask

   task automatic t_fail_mid();
      int b, d, e;
      build_exp(24'h321123, 6'b000100);
      run_event(24'h321123, 6'b000100, 8'd0, 1'b0, b, d, e);
      cmp_stream(b, "R6 single bypass");
      build_exp(24'h123456, 6'b101010);
      run_event(24'h123456, 6'b101010, 8'd0, 1'b0, b, d, e);
      cmp_stream(b, "R6 alternating bypass");
      chk(cap[ncap-1] == mk(2'b11, 4, 0), "R5 end after bypass", cap[ncap-1], mk(2'b11, 4, 0));
   endtask

   task automatic t_fail_master();
      int b, d, e;
      build_exp(24'h222227, 6'b000001);
      run_event(24'h222227, 6'b000001, 8'd0, 1'b0, b, d, e);
      chk(cap[b] == mk(2'b01, 1, 2), "R4 master moves to position 1", cap[b], mk(2'b01, 1, 2));
      cmp_stream(b, "R4 stream without chip 0");
   endtask

   task automatic t_fail_end();
      int b, d, e;
      build_exp(24'h911111, 6'b100000);
      run_event(24'h911111, 6'b100000, 8'd0, 1'b0, b, d, e);
      chk(cap[ncap-1] == mk(2'b11, 4, 0), "R5 trailer from position 4", cap[ncap-1], mk(2'b11, 4, 0));
      cmp_stream(b, "R5 stream without last chip");
   endtask

   task automatic t_adjacent();
      int b, d, e;
      @(negedge clk);
      fail_mask = 6'b011000;
      @(negedge clk);
      chk(cfg_err == 1'b1, "R7 cfg_err raised", cfg_err, 1);
      run_event(24'h111111, 6'b011000, 8'd0, 1'b0, b, d, e);
      chk(ncap - b == 0, "R7 no words", ncap - b, 0);
      chk(ndone - d == 0, "R7 no done", ndone - d, 0);
      @(negedge clk);
      fail_mask = 6'b010100;
      @(negedge clk);
      chk(cfg_err == 1'b0, "R7 split failures accepted", cfg_err, 0);
   endtask

   task automatic t_timeout();
      int b, d, e, n, at;
      build_exp(24'h333332, 6'b000000);
      run_event(24'h333332, 6'b000000, 8'd4, 1'b0, b, d, e);
      n = ncap - b;
      chk(n > 0 && n < nexp, "R9 stream cut short", n, nexp);
      chk(cap[ncap-1] == mk(2'b11, 0, 1), "R9 error trailer", cap[ncap-1], mk(2'b11, 0, 1));
      chk(nerrev - e == 1 && ndone - d == 1, "R9 err with done", {ndone - d, nerrev - e}, 17);
      at = -1;
      for (int k = 0; k < n - 1; k++) if (at < 0 && cap[b+k] !== exp_w[k]) at = k;
      chk(at < 0, "R9 prefix before timeout", at, -1);
      build_exp(24'hffffff, 6'b000000);
      run_event(24'hffffff, 6'b000000, 8'd0, 1'b0, b, d, e);
      cmp_stream(b, "R9 disabled watchdog");
      chk(nerrev - e == 0, "R9 no error when disabled", nerrev - e, 0);
      run_event(24'h333332, 6'b000000, 8'd250, 1'b0, b, d, e);
      chk(nerrev - e == 0, "R9 generous limit", nerrev - e, 0);
   endtask

   task automatic t_busy();
      int b, d, e;
      build_exp(24'h444444, 6'b000000);
      run_event(24'h444444, 6'b000000, 8'd0, 1'b1, b, d, e);
      cmp_stream(b, "R10 second trigger ignored");
      chk(ndone - d == 1, "R10 single event", ndone - d, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_zero();
      t_fail_mid();
      t_fail_master();
      t_fail_end();
      t_adjacent();
      t_timeout();
      t_busy();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_fail);
      $finish;
   end
endmodule